// File: doc/BRIEF.md
# Crest Factor Overcurrent Detector

This block watches a stream of digitized switch-node samples taken while the low-side switch of a half bridge conducts, and decides when the current peak has grown far above its long-term level. Each low-side on-interval starts with a blanking interval, so that the edge and any hard-switching spike cannot reach the detector. Only samples that arrive after that interval count. They are folded into a per-interval mean, and the means feed a slow exponential average that spans roughly ten to twenty switching periods. A sample that rises above a fixed multiple of that average marks a saturating inductor or a lamp that failed to strike.

The mode controller arms the check only in run mode. After arming, the average must take in a minimum number of fresh periods before any fault can be declared. The result is a single-cycle fault pulse that the bridge shutdown logic latches. After one pulse the detector stays silent until reset. A status output reports when the average is so large that its multiple would leave the sensing range.

Top module: `crest_factor_detector`

## Requirements
- R1: A sample is qualified only when `smp_valid` is high, `lo_on` is high and the blanking interval has elapsed. Samples offered while `lo_on` is low never raise a fault and never enter the average.
- R2: The blanking interval is the first BLANK_CYC (default 50) clock cycles of every `lo_on` high interval, counting the first cycle in which `lo_on` is seen high. Samples in those cycles are ignored.
- R3: On the first clock in which `lo_on` is seen low after being high, the floor of (sum / count) of that interval's qualified samples is taken as the interval mean. An interval with no qualified sample leaves the average and the fill count unchanged.
- R4: The average register `acc` resets to zero and is updated with each interval mean as acc + mean - (acc >> EMA_SHIFT), with EMA_SHIFT defaulting to 4. The average equals acc >> EMA_SHIFT, and the new value is in effect from the clock after the update.
- R5: A fault condition is a qualified sample strictly greater than CF_MULT (default 5) times the average as it stood before the current interval's update. A sample equal to the product is not a fault. The product is computed wide enough never to wrap, even at a full-scale average.
- R6: While `arm_en` is low, no fault is raised and the fill count is held at zero.
- R7: After `arm_en` goes high, a fault can be raised only once FILL_CYC (default 16) average updates have completed while `arm_en` stayed high.
- R8: `fault_pulse` is high for exactly one clock, the cycle after the clock edge that sampled the offending sample. At most one pulse is produced between resets.
- R9: `avg_over_range` is high exactly while the average exceeds AVG_LIMIT (default 300).
- R10: While `rst_n` is low, both outputs are low. The average and the fill count return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_on | input | 1 | Low-side gate drive level, high while the low switch conducts |
| arm_en | input | 1 | Run-mode enable from the mode controller |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SMP_W | Unsigned switch-node sample |
| fault_pulse | output | 1 | One-clock crest-factor fault indication |
| avg_over_range | output | 1 | Average above the sensing-range limit |

## Verification
On every cycle, the assertions confirm the following. A fault pulse follows only a sample seen with the low switch on, the block armed and the fill complete. The pulse never repeats. The average moves only on an update strobe. The threshold product and the accumulator never wrap, and the interval mean fits the sample width. Other behaviours can be shown only by the bench scenarios, checked cycle by cycle against a behavioural model. These are the exact blanking boundary, strict versus equal comparison against five times the average, intervals without samples leaving the average alone, the fill count restarting when arming drops, and the over-range flag turning on as the average climbs.

// File: rtl/cf_pkg.sv
package cf_pkg;

   typedef enum logic [1:0] {
      WIN_IDLE  = 2'd0,
      WIN_BLANK = 2'd1,
      WIN_OPEN  = 2'd2
   } win_state_t;

   function automatic int thr_width(input int avg_w, input int mult);
      return avg_w + $clog2(mult + 1);
   endfunction

endpackage

// File: rtl/cf_window.sv
module cf_window
   import cf_pkg::*;
#(
   parameter int BLANK_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lo_on,
   output logic win_o,
   output logic cyc_end_o
);

   localparam int CNT_W = $clog2(BLANK_CYC + 1);

   if (BLANK_CYC < 1) begin : g_chk_blank
      $error("cf_window: BLANK_CYC must be at least 1");
   end

   win_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WIN_IDLE;
         cnt_q   <= '0;
      end else if (!lo_on) begin
         state_q <= WIN_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            WIN_IDLE: begin
               if (BLANK_CYC == 1) state_q <= WIN_OPEN;
               else                state_q <= WIN_BLANK;
               cnt_q <= CNT_W'(BLANK_CYC - 1);
            end
            WIN_BLANK: begin
               if (cnt_q == CNT_W'(1)) state_q <= WIN_OPEN;
               else                    cnt_q   <= cnt_q - CNT_W'(1);
            end
            default: state_q <= WIN_OPEN;
         endcase
      end
   end

   assign win_o     = lo_on && (state_q == WIN_OPEN);
   assign cyc_end_o = !lo_on && (state_q != WIN_IDLE);

   AST_BLANK_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_on) |-> !win_o); // R2
   AST_END_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end_o |-> $past(lo_on)); // R3

endmodule

// File: rtl/cf_div.sv
module cf_div #(
   parameter int NUM_W = 18,
   parameter int DEN_W = 8
) (
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic [NUM_W-1:0] quo_o
);

   if (NUM_W < 2 || DEN_W < 1) begin : g_chk_w
      $error("cf_div: operand widths too small");
   end

   logic [NUM_W-1:0][DEN_W-1:0] rem;
   assign rem[0] = '0;

   for (genvar k = 0; k < NUM_W; k++) begin : g_stage
      logic [DEN_W:0] trial;
      logic           take;
      assign trial = {rem[k], num_i[NUM_W-1-k]};
      assign take  = (trial >= {1'b0, den_i});
      assign quo_o[NUM_W-1-k] = take;
      if (k < NUM_W - 1) begin : g_next
         logic [DEN_W-1:0] diff;
         assign diff       = trial[DEN_W-1:0] - den_i;
         assign rem[k+1]   = take ? diff : trial[DEN_W-1:0];
      end
   end

endmodule

// File: rtl/cf_accum.sv
module cf_accum #(
   parameter int SMP_W   = 10,
   parameter int MAX_SMP = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qual_i,
   input  logic [SMP_W-1:0] smp_i,
   input  logic             cyc_end_i,
   output logic             upd_o,
   output logic [SMP_W-1:0] mean_o
);

   localparam int CNT_W = $clog2(MAX_SMP + 1);
   localparam int SUM_W = SMP_W + CNT_W;

   if (MAX_SMP < 2) begin : g_chk_max
      $error("cf_accum: MAX_SMP must be at least 2");
   end

   logic [SUM_W-1:0] sum_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] quo;

   always_ff @(posedge clk) begin
      if (!rst_n || cyc_end_i) begin
         sum_q <= '0;
         cnt_q <= '0;
      end else if (qual_i && (cnt_q != CNT_W'(MAX_SMP))) begin
         sum_q <= sum_q + SUM_W'(smp_i);
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   cf_div #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_div (
      .num_i (sum_q),
      .den_i (cnt_q),
      .quo_o (quo)
   );

   assign upd_o  = cyc_end_i && (cnt_q != '0);
   assign mean_o = quo[SMP_W-1:0];

   AST_MEAN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |-> (quo[SUM_W-1:SMP_W] == '0)); // R3
   AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(MAX_SMP)) |=> (cnt_q == CNT_W'(MAX_SMP)) || $past(cyc_end_i)); // R3

endmodule

// File: rtl/cf_ema.sv
module cf_ema #(
   parameter int SMP_W     = 10,
   parameter int EMA_SHIFT = 4,
   parameter int FILL_CYC  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_i,
   input  logic [SMP_W-1:0] mean_i,
   input  logic             arm_i,
   output logic [SMP_W-1:0] avg_o,
   output logic             filled_o
);

   localparam int ACC_W  = SMP_W + EMA_SHIFT;
   localparam int NX_W   = ACC_W + 1;
   localparam int FILL_W = $clog2(FILL_CYC + 1);

   if (EMA_SHIFT < 1 || FILL_CYC < 1) begin : g_chk_ema
      $error("cf_ema: EMA_SHIFT and FILL_CYC must be at least 1");
   end

   logic [ACC_W-1:0]  acc_q;
   logic [NX_W-1:0]   acc_nx;
   logic [FILL_W-1:0] fill_q;

   assign acc_nx = {1'b0, acc_q} - NX_W'(acc_q >> EMA_SHIFT) + NX_W'(mean_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (upd_i) begin
         acc_q <= acc_nx[ACC_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !arm_i) begin
         fill_q <= '0;
      end else if (upd_i && (fill_q != FILL_W'(FILL_CYC))) begin
         fill_q <= fill_q + FILL_W'(1);
      end
   end

   assign avg_o    = acc_q[ACC_W-1:EMA_SHIFT];
   assign filled_o = (fill_q == FILL_W'(FILL_CYC));

   AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |-> !acc_nx[ACC_W]); // R4
   AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(avg_o)); // R3
   AST_FILL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_i |=> !filled_o); // R6

endmodule

// File: rtl/cf_thresh.sv
module cf_thresh #(
   parameter int AVG_W   = 10,
   parameter int CF_MULT = 5,
   parameter int THR_W   = 13
) (
   input  logic [AVG_W-1:0] avg_i,
   output logic [THR_W-1:0] thr_o
);

   localparam int SH = $clog2(CF_MULT);

   if (CF_MULT < 2) begin : g_chk_mult
      $error("cf_thresh: CF_MULT must be at least 2");
   end
   if (THR_W < AVG_W + SH) begin : g_chk_w
      $error("cf_thresh: THR_W too narrow for the product");
   end

   if (CF_MULT == 5) begin : g_x5
      assign thr_o = (THR_W'(avg_i) << 2) + THR_W'(avg_i);
   end else if ((1 << SH) == CF_MULT) begin : g_pow2
      assign thr_o = THR_W'(avg_i) << SH;
   end else begin : g_mul
      assign thr_o = THR_W'(avg_i) * THR_W'(CF_MULT);
   end

endmodule

// File: rtl/crest_factor_detector.sv
module crest_factor_detector
   import cf_pkg::*;
#(
   parameter int SMP_W     = 10,
   parameter int BLANK_CYC = 50,
   parameter int MAX_SMP   = 255,
   parameter int EMA_SHIFT = 4,
   parameter int FILL_CYC  = 16,
   parameter int CF_MULT   = 5,
   parameter int AVG_LIMIT = 300
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_on,
   input  logic             arm_en,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic             fault_pulse,
   output logic             avg_over_range
);

   localparam int THR_W = thr_width(SMP_W, CF_MULT);

   if (AVG_LIMIT < 0 || AVG_LIMIT >= (1 << SMP_W)) begin : g_chk_lim
      $error("crest_factor_detector: AVG_LIMIT outside the sample range");
   end

   logic             win;
   logic             cyc_end;
   logic             qual;
   logic             upd;
   logic [SMP_W-1:0] mean;
   logic [SMP_W-1:0] avg;
   logic             filled;
   logic [THR_W-1:0] thr;
   logic             hit;
   logic             fault_q;
   logic             done_q;

   cf_window #(.BLANK_CYC(BLANK_CYC)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .lo_on     (lo_on),
      .win_o     (win),
      .cyc_end_o (cyc_end)
   );

   assign qual = smp_valid && win;

   cf_accum #(.SMP_W(SMP_W), .MAX_SMP(MAX_SMP)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual_i    (qual),
      .smp_i     (smp_data),
      .cyc_end_i (cyc_end),
      .upd_o     (upd),
      .mean_o    (mean)
   );

   cf_ema #(.SMP_W(SMP_W), .EMA_SHIFT(EMA_SHIFT), .FILL_CYC(FILL_CYC)) u_ema (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_i    (upd),
      .mean_i   (mean),
      .arm_i    (arm_en),
      .avg_o    (avg),
      .filled_o (filled)
   );

   cf_thresh #(.AVG_W(SMP_W), .CF_MULT(CF_MULT), .THR_W(THR_W)) u_thr (
      .avg_i (avg),
      .thr_o (thr)
   );

   assign hit = qual && arm_en && filled && !done_q && (THR_W'(smp_data) > thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         fault_q <= hit;
         done_q  <= done_q || hit;
      end
   end

   assign fault_pulse    = fault_q;
   assign avg_over_range = (avg > SMP_W'(AVG_LIMIT));

   AST_FAULT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> $past(lo_on) && $past(smp_valid)); // R1
   AST_THR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      thr >= THR_W'(avg)); // R5
   AST_FAULT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> $past(arm_en)); // R6
   AST_FAULT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> $past(filled)); // R7
   AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |=> !fault_pulse); // R8
   AST_FAULT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done_q) |-> !fault_pulse); // R8

endmodule

// File: tb/tb_crest_factor_detector.sv
module tb_crest_factor_detector;

   localparam int CLK_PERIOD = 10;
   localparam int B    = 50;
   localparam int SH   = 4;
   localparam int FILL = 16;
   localparam int MUL  = 5;
   localparam int LIM  = 300;
   localparam int MAXS = 255;
   localparam int HI_LEN = 80;
   localparam int LO_LEN = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lo_on = 1'b0;
   logic       arm_en = 1'b0;
   logic       smp_valid = 1'b0;
   logic [9:0] smp_data = '0;
   logic       fault_pulse;
   logic       avg_over_range;

   int n_run = 0;
   int n_fail = 0;
   int n_flt = 0;
   bit cmp_en = 1'b0;
   bit finished = 1'b0;

   // behavioural reference state
   int m_lo_q = 0, m_hc = 0, m_sum = 0, m_cnt = 0, m_acc = 0, m_fill = 0;
   int m_done = 0, m_fault = 0;

   crest_factor_detector dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .lo_on          (lo_on),
      .arm_en         (arm_en),
      .smp_valid      (smp_valid),
      .smp_data       (smp_data),
      .fault_pulse    (fault_pulse),
      .avg_over_range (avg_over_range)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin : model
      int avg, mean, hc, qual, hit;
      if (!rst_n) begin
         m_lo_q = 0; m_hc = 0; m_sum = 0; m_cnt = 0; m_acc = 0;
         m_fill = 0; m_done = 0; m_fault = 0;
      end else begin
         avg  = m_acc >> SH;
         hc   = lo_on ? m_hc + 1 : 0;
         qual = (lo_on && smp_valid && hc > B) ? 1 : 0;
         hit  = (qual && arm_en && m_fill >= FILL && !m_done &&
                 int'(smp_data) > MUL * avg) ? 1 : 0;
         m_fault = hit;
         if (hit) m_done = 1;
         if (!lo_on && m_lo_q) begin
            if (m_cnt > 0) begin
               mean  = m_sum / m_cnt;
               m_acc = m_acc - (m_acc >> SH) + mean;
               if (arm_en && m_fill < FILL) m_fill = m_fill + 1;
            end
            m_sum = 0; m_cnt = 0;
         end else if (qual && m_cnt < MAXS) begin
            m_sum = m_sum + int'(smp_data);
            m_cnt = m_cnt + 1;
         end
         if (!arm_en) m_fill = 0;
         m_hc   = hc;
         m_lo_q = lo_on ? 1 : 0;
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (fault_pulse === 1'b1) n_flt++;
      if (cmp_en) begin
         check(fault_pulse === 1'(m_fault), "R1/R2/R5/R8 fault_pulse vs model",
               int'(fault_pulse), m_fault);
         check(avg_over_range === 1'((m_acc >> SH) > LIM), "R4/R9 avg_over_range vs model",
               int'(avg_over_range), int'((m_acc >> SH) > LIM));
      end
   end

   task automatic lo_cyc(input int base, input int spk, input int spk_idx,
                         input bit spk_low, input bit vld);
      for (int i = 0; i < HI_LEN; i++) begin
         @(negedge clk);
         lo_on = 1'b1; smp_valid = vld;
         smp_data = 10'((!spk_low && i == spk_idx) ? spk : base);
      end
      for (int i = 0; i < LO_LEN; i++) begin
         @(negedge clk);
         lo_on = 1'b0; smp_valid = 1'b1;
         smp_data = 10'((spk_low && i == 5) ? spk : base);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; lo_on = 1'b0; smp_valid = 1'b0; arm_en = 1'b0;
      repeat (3) @(negedge clk);
      check(fault_pulse === 1'b0, "R10 fault_pulse in reset", int'(fault_pulse), 0);
      check(avg_over_range === 1'b0, "R10 avg_over_range in reset", int'(avg_over_range), 0);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      int base_f, avg_sv;
      repeat (2) @(negedge clk);
      cmp_en = 1'b1;
      do_reset();

      // disarmed: spikes ignored
      for (int c = 0; c < 20; c++) lo_cyc(40, 1023, (c == 10) ? 60 : -1, 1'b0, 1'b1);
      check(n_flt == 0, "R6 no fault while disarmed", n_flt, 0);

      // armed, filling
      arm_en = 1'b1;
      for (int c = 0; c < 15; c++) lo_cyc(40, 1023, 60, 1'b0, 1'b1);
      check(n_flt == 0, "R7 no fault before fill", n_flt, 0);
      lo_cyc(40, 1023, 10, 1'b0, 1'b1);
      check(n_flt == 0, "R2 spike inside blank ignored", n_flt, 0);
      lo_cyc(40, 1023, 0, 1'b1, 1'b1);
      check(n_flt == 0, "R1 spike with LO low ignored", n_flt, 0);

      // intervals with no samples keep the average
      avg_sv = m_acc >> SH;
      for (int c = 0; c < 3; c++) lo_cyc(0, 0, -1, 1'b0, 1'b0);
      check((m_acc >> SH) == avg_sv, "R3 model average after empty intervals", m_acc >> SH, avg_sv);
      lo_cyc(40, MUL * avg_sv, 60, 1'b0, 1'b1);
      check(n_flt == 0, "R5 sample equal to product is no fault", n_flt, 0);
      lo_cyc(40, 1023, B - 1, 1'b0, 1'b1);
      check(n_flt == 0, "R2 last blanked cycle ignored", n_flt, 0);
      avg_sv = m_acc >> SH;
      lo_cyc(40, MUL * avg_sv + 1, B, 1'b0, 1'b1);
      check(n_flt == 1, "R5 R3 first open cycle above product faults", n_flt, 1);
      lo_cyc(40, 1023, 60, 1'b0, 1'b1);
      check(n_flt == 1, "R8 no second fault before reset", n_flt, 1);

      // arm drop clears fill
      do_reset();
      base_f = n_flt;
      arm_en = 1'b1;
      for (int c = 0; c < 20; c++) lo_cyc(40, 0, -1, 1'b0, 1'b1);
      arm_en = 1'b0;
      lo_cyc(40, 0, -1, 1'b0, 1'b1);
      arm_en = 1'b1;
      lo_cyc(40, 1023, 60, 1'b0, 1'b1);
      check(n_flt - base_f == 0, "R6 fill restarted after arm drop", n_flt - base_f, 0);
      for (int c = 0; c < 15; c++) lo_cyc(40, 0, -1, 1'b0, 1'b1);
      lo_cyc(40, 1023, 60, 1'b0, 1'b1);
      check(n_flt - base_f == 1, "R7 fault once refilled", n_flt - base_f, 1);

      // large average: over-range and wide product
      do_reset();
      base_f = n_flt;
      arm_en = 1'b1;
      lo_cyc(700, 0, -1, 1'b0, 1'b1);
      check(avg_over_range === 1'b0, "R9 flag low for small average", int'(avg_over_range), 0);
      for (int c = 0; c < 40; c++) lo_cyc(700, 0, -1, 1'b0, 1'b1);
      check(avg_over_range === 1'b1, "R9 flag high for large average", int'(avg_over_range), 1);
      lo_cyc(700, 1023, 60, 1'b0, 1'b1);
      check(n_flt - base_f == 0, "R5 full-scale sample under wide product", n_flt - base_f, 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule